// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. It takes two operands and a five-bit condition mask. Each mask bit enables one relation between the operands: signed less-than, signed greater-than, equality, unsigned less-than or unsigned greater-than. If any enabled relation holds, the block raises a trap request.

A width select chooses the operand size. In doubleword mode all bits of both operands are compared. In word mode only the lower half of each operand is used, interpreted as a signed or unsigned half-width value. The decision is registered. It appears one clock after the valid strobe, together with a done strobe and a program-exception cause code that means "trap". Delivering the exception is left to the surrounding pipeline.

Top module: `trap_cmp_top`

## Requirements
- R1: With mask bit 4 set, a trap is raised when A is less than B as signed values.
- R2: With mask bit 3 set, a trap is raised when A is greater than B as signed values.
- R3: With mask bit 2 set, a trap is raised when A equals B.
- R4: With mask bit 1 set, a trap is raised when A is less than B as unsigned values.
- R5: With mask bit 0 set, a trap is raised when A is greater than B as unsigned values.
- R6: With `dword_i` low (word mode), only the lower DATA_W/2 bits of each operand take part, as signed or unsigned values of that width; the upper bits have no effect on the result. With `dword_i` high, all DATA_W bits are compared.
- R7: The trap result is the OR of all enabled relation matches. A mask of 0 never traps, and a mask of 5'b11111 always traps.
- R8: `done_o` is high exactly in the cycle after a cycle with `valid_i` high, and the trap result for that request is presented in that same cycle. `trap_o` is low whenever `done_o` is low.
- R9: `code_o` equals the trap cause code (default 4'h4) when `trap_o` is high, and is 0 otherwise.
- R10: While reset is asserted, and after its release until the first request, `done_o`, `trap_o` and `code_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| valid_i | input | 1 | Request strobe for a trap evaluation |
| dword_i | input | 1 | 1 selects full-width compare, 0 selects lower-half (word) compare |
| mask_i | input | 5 | Condition mask: bit 4 signed lt, bit 3 signed gt, bit 2 eq, bit 1 unsigned lt, bit 0 unsigned gt |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| done_o | output | 1 | Result strobe, one cycle after `valid_i` |
| trap_o | output | 1 | Trap request for the completed evaluation |
| code_o | output | CODE_W | Program-exception cause code; the trap code when `trap_o` is high, else 0 |

## Verification
The bench builds the block with DATA_W = 6, so a word is 3 bits wide. At that size every pair of operands can be swept in both width modes. Each pair is run under the zero mask, each single-relation mask, the all-ones mask and one mixed mask. This covers every sign boundary, the equal case and the case where the word halves order differently from the full values. In word mode the upper operand bits range over all values, so their lack of effect is shown directly.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

  // number of relations a mask can enable
  localparam int REL_N = 5;

  // relation flags; packed order mirrors the mask bit positions (msb = bit 4)
  typedef struct packed {
    logic lt_s;   // bit 4
    logic gt_s;   // bit 3
    logic eq;     // bit 2
    logic lt_u;   // bit 1
    logic gt_u;   // bit 0
  } rel_t;

  localparam int CODE_W_DEF = 4;
  localparam logic [CODE_W_DEF-1:0] TRAP_CODE_DEF = 4'h4;

endpackage

// File: rtl/trap_rst_sync.sv
module trap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/trap_operand_fmt.sv
module trap_operand_fmt #(
  parameter int DATA_W = 64,
  parameter int HALF_W = DATA_W / 2
) (
  input  logic              dword,
  input  logic [DATA_W-1:0] opd,
  output logic [DATA_W-1:0] opd_sx,
  output logic [DATA_W-1:0] opd_zx
);

  localparam int EXT_W = DATA_W - HALF_W;

  logic [HALF_W-1:0] low_half;
  logic              low_sign;

  assign low_half = opd[HALF_W-1:0];
  assign low_sign = opd[HALF_W-1];

  generate
    if (EXT_W > 0) begin : g_ext
      always_comb begin
        if (dword) begin
          opd_sx = opd;
          opd_zx = opd;
        end else begin
          opd_sx = {{EXT_W{low_sign}}, low_half};
          opd_zx = {{EXT_W{1'b0}}, low_half};
        end
      end
    end else begin : g_flat
      always_comb begin
        opd_sx = opd;
        opd_zx = opd;
      end
    end
  endgenerate

endmodule

// File: rtl/trap_rel_unit.sv
module trap_rel_unit
  import trap_cmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_sx,
  input  logic [DATA_W-1:0] b_sx,
  input  logic [DATA_W-1:0] a_zx,
  input  logic [DATA_W-1:0] b_zx,
  output rel_t              rel
);

  always_comb begin
    rel.lt_s = $signed(a_sx) < $signed(b_sx);
    rel.gt_s = $signed(a_sx) > $signed(b_sx);
    rel.eq   = (a_zx == b_zx);
    rel.lt_u = a_zx < b_zx;
    rel.gt_u = a_zx > b_zx;
  end

endmodule

// File: rtl/trap_mask_combine.sv
module trap_mask_combine #(
  parameter int REL_N = 5
) (
  input  logic [REL_N-1:0] rel_vec,
  input  logic [REL_N-1:0] mask,
  output logic             hit
);

  logic [REL_N-1:0] sel;

  generate
    for (genvar g = 0; g < REL_N; g++) begin : g_sel
      assign sel[g] = rel_vec[g] & mask[g];
    end
  endgenerate

  assign hit = |sel;

endmodule

// File: rtl/trap_cmp_top.sv
module trap_cmp_top
  import trap_cmp_pkg::*;
#(
  parameter int                DATA_W    = 64,
  parameter int                CODE_W    = CODE_W_DEF,
  parameter logic [CODE_W-1:0] TRAP_CODE = TRAP_CODE_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              dword_i,
  input  logic [REL_N-1:0]  mask_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              done_o,
  output logic              trap_o,
  output logic [CODE_W-1:0] code_o
);

  localparam int HALF_W = DATA_W / 2;

  logic rst_sync_n;

  trap_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // operand formatting for the selected width
  logic [DATA_W-1:0] a_sx, a_zx, b_sx, b_zx;

  trap_operand_fmt #(.DATA_W(DATA_W), .HALF_W(HALF_W)) i_fmt_a (
    .dword  (dword_i),
    .opd    (a_i),
    .opd_sx (a_sx),
    .opd_zx (a_zx)
  );

  trap_operand_fmt #(.DATA_W(DATA_W), .HALF_W(HALF_W)) i_fmt_b (
    .dword  (dword_i),
    .opd    (b_i),
    .opd_sx (b_sx),
    .opd_zx (b_zx)
  );

  rel_t rel;

  trap_rel_unit #(.DATA_W(DATA_W)) i_rel (
    .a_sx (a_sx),
    .b_sx (b_sx),
    .a_zx (a_zx),
    .b_zx (b_zx),
    .rel  (rel)
  );

  logic hit;

  trap_mask_combine #(.REL_N(REL_N)) i_comb (
    .rel_vec (rel),
    .mask    (mask_i),
    .hit     (hit)
  );

  // next-state
  logic              done_q, done_d;
  logic              trap_q, trap_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              res_en;

  always_comb begin
    res_en = valid_i | done_q;
    done_d = valid_i;
    trap_d = valid_i & hit;
    code_d = (valid_i & hit) ? TRAP_CODE : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      code_q <= '0;
    end else if (res_en) begin
      done_q <= done_d;
      trap_q <= trap_d;
      code_q <= code_d;
    end
  end

  assign done_o = done_q;
  assign trap_o = trap_q;
  assign code_o = code_q;

  // checks beside the result stage
  p_done_follows_valid_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_i |=> done_o);

  p_no_spurious_done_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !valid_i |=> !done_o);

  p_trap_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_o |-> done_o);

  p_zero_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && mask_i == '0) |=> !trap_o);

  p_full_mask_fires_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && mask_i == '1) |=> trap_o);

  p_equal_fires_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && mask_i[2] && a_i == b_i) |=> trap_o);

  p_code_matches_trap_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (code_o != '0) == trap_o);

  p_relations_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_i |-> $onehot0({rel.lt_s, rel.gt_s, rel.eq}));

endmodule

// File: tb/test_trap_cmp_top.sv
module test_trap_cmp_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 6;
  localparam int HW = 3;
  localparam int CW = 4;
  localparam logic [CW-1:0] TRAP_CODE = 4'h4;

  logic          clk;
  logic          rst_n;
  logic          valid_i;
  logic          dword_i;
  logic [4:0]    mask_i;
  logic [DW-1:0] a_i, b_i;
  logic          done_o, trap_o;
  logic [CW-1:0] code_o;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  trap_cmp_top #(.DATA_W(DW), .CODE_W(CW), .TRAP_CODE(TRAP_CODE)) i_trap_cmp_top (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .dword_i (dword_i),
    .mask_i  (mask_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .done_o  (done_o),
    .trap_o  (trap_o),
    .code_o  (code_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic bit ref_trap(input logic [4:0] m, input int a, input int b,
                                  input bit dw);
    int sa, sb, ua, ub;
    if (dw) begin
      ua = a; ub = b;
      sa = (a >= (1 << (DW-1))) ? a - (1 << DW) : a;
      sb = (b >= (1 << (DW-1))) ? b - (1 << DW) : b;
    end else begin
      ua = a % (1 << HW); ub = b % (1 << HW);
      sa = (ua >= (1 << (HW-1))) ? ua - (1 << HW) : ua;
      sb = (ub >= (1 << (HW-1))) ? ub - (1 << HW) : ub;
    end
    return (m[4] && sa < sb) || (m[3] && sa > sb) || (m[2] && ua == ub) ||
           (m[1] && ua < ub) || (m[0] && ua > ub);
  endfunction

  function automatic logic [4:0] pick_mask(input int k, input int a, input int b);
    case (k)
      0: return 5'b00000;
      1: return 5'b10000;
      2: return 5'b01000;
      3: return 5'b00100;
      4: return 5'b00010;
      5: return 5'b00001;
      6: return 5'b11111;
      default: return 5'((a ^ (b << 1) ^ (a >> 2)) & 31);
    endcase
  endfunction

  function automatic string pick_tag(input int k, input bit dw);
    string t;
    case (k)
      1: t = "R1";
      2: t = "R2";
      3: t = "R3";
      4: t = "R4";
      5: t = "R5";
      default: t = "R7";
    endcase
    if (!dw) t = {t, "/R6"};
    return t;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit    have_prev;
    bit    prev_exp;
    string prev_tag;
    have_prev = 0;
    prev_exp  = 0;
    prev_tag  = "";
    rst_n   = 1'b0;
    valid_i = 1'b0;
    dword_i = 1'b0;
    mask_i  = '0;
    a_i     = '0;
    b_i     = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 done in reset", done_o, 0);
    chk("R10 trap in reset", trap_o, 0);
    chk("R10 code in reset", code_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 done after release", done_o, 0);
    chk("R10 trap after release", trap_o, 0);
    chk("R10 code after release", code_o, 0);

    for (int dwi = 0; dwi < 2; dwi++) begin
      for (int a = 0; a < (1 << DW); a++) begin
        for (int b = 0; b < (1 << DW); b++) begin
          for (int k = 0; k < 8; k++) begin
            if (have_prev) begin
              chk("R8 done", done_o, 1);
              chk(prev_tag, trap_o, prev_exp);
              chk("R9 code", code_o, prev_exp ? TRAP_CODE : 0);
            end
            valid_i  = 1'b1;
            dword_i  = dwi[0];
            a_i      = DW'(a);
            b_i      = DW'(b);
            mask_i   = pick_mask(k, a, b);
            prev_exp = ref_trap(mask_i, a, b, dwi[0]);
            prev_tag = pick_tag(k, dwi[0]);
            have_prev = 1;
            @(negedge clk);
          end
        end
      end
    end
    chk("R8 done last", done_o, 1);
    chk(prev_tag, trap_o, prev_exp);
    chk("R9 code last", code_o, prev_exp ? TRAP_CODE : 0);

    // idle with an all-ones mask on the pins: nothing should complete
    valid_i = 1'b0;
    mask_i  = 5'b11111;
    @(negedge clk);
    chk("R8 done idle", done_o, 0);
    chk("R8 trap idle", trap_o, 0);
    chk("R9 code idle", code_o, 0);
    @(negedge clk);
    chk("R8 done idle 2", done_o, 0);

    finish_run();
  end

endmodule